// File: doc/BRIEF.md
# Flow-Through Synchronous Burst SRAM

A behavioural, synthesizable model of a synchronous cache SRAM with a shared bidirectional data bus. A new access begins when either of two address strobes, one meant for a processor and one for a cache controller, is high at a rising clock edge. That edge captures the address and the burst-order mode. The word at the captured address then appears on the bus within the next cycle without a second clock edge, because the read path has no output register. The resulting timing is two cycles for the first beat and one cycle for each following beat.

An internal 2-bit beat counter moves through the four words of an aligned group whenever the advance input is high at an edge. The order is either linear, where the offset is added modulo 4, or interleaved, where the offset is XORed into the low address bits. Writes are fully synchronous: bus data and four byte-lane enables are captured on the clock edge. Output enable and the write-cycle flag release the bus without waiting for a clock edge. A sleep input freezes the block, releases the bus and ends any burst, while keeping the stored words.

The word count is set by the `ADDR_W` parameter. `ADDR_W` = 15 gives the full 32K x 32 organisation. The default is smaller so that the array stays cheap to elaborate.

Top module: `fts_burst_sram`

## Requirements
- R1: After reset no burst is active, and the bus is not driven even with `oe` high.
- R2: When a strobe is high at an edge with `sleep` low, then during the following cycle, with `oe`=1 and `wr`=0, `data` carries the word stored at the captured address. No further clock edge is needed.
- R3: With `lin_mode`=1 sampled at the strobe edge, beat n accesses low address bits (base[1:0] + n) mod 4.
- R4: With `lin_mode`=0 sampled at the strobe edge, beat n accesses low address bits base[1:0] XOR n. In both orders, address bits above bit 1 stay fixed for the whole burst.
- R5: `cpu_strobe` and `ctl_strobe` each start a new burst at beat 0 from `addr`. A strobe takes priority over `adv` in the same cycle.
- R6: When `adv` is low at an edge, the current address is held. When `adv` is high, the beat counter steps by one and wraps from beat 3 back to beat 0.
- R7: When `wr`=1 at an edge during a burst, each lane i with `byte_we[i]`=1 stores `data[8i+7:8i]` at the current address. Lanes with `byte_we[i]`=0 keep their old contents.
- R8: Whenever `oe`=0 or `wr`=1, the block releases `data` combinationally, within the same cycle.
- R9: While `sleep`=1, the bus is released and the strobes, `adv` and `wr` have no effect. Stored words are kept.
- R10: After `sleep` falls, no burst is active until a strobe arrives.
- R11: When a write and a strobe fall on the same edge, the write lands at the old burst address and the new burst starts from `addr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| addr | input | ADDR_W | Word address, captured on a strobe edge |
| cpu_strobe | input | 1 | Processor address strobe, active high |
| ctl_strobe | input | 1 | Controller address strobe, active high |
| adv | input | 1 | Step the burst by one beat |
| lin_mode | input | 1 | 1 selects linear order, 0 selects interleaved order; sampled with the strobe |
| wr | input | 1 | Write cycle flag; the write is performed at the edge |
| byte_we | input | DATA_W/8 | Per-lane write enables, bit i gates bits 8i+7..8i |
| oe | input | 1 | Asynchronous output enable |
| sleep | input | 1 | Low-power freeze |
| data | inout | DATA_W | Shared read/write data bus |

## Verification
The block has two pairs of functions that can act on the same clock edge. The first pair is a write to the current beat and a strobe that begins a new burst. The second pair is sleep and a pending strobe, write or advance. The bench provokes both pairs with directed steps and also leaves them to arise in a long random run. After each edge it compares the bus against a bench-side word model and burst pointer: the write must land at the old address, and sleep must win over every other input. Reads on the following beats, and a strobe back to the written address after sleep, expose any misplaced or leaked update.

// File: rtl/fts_sram_pkg.sv
package fts_sram_pkg;

   typedef enum logic {
      ORDER_INTERLEAVE = 1'b0,
      ORDER_LINEAR     = 1'b1
   } burst_order_e;

   // Low two address bits for a given beat within the aligned group of four.
   function automatic logic [1:0] beat_offset(input logic [1:0]   base_lo,
                                              input logic [1:0]   beat,
                                              input burst_order_e ord);
      if (ord == ORDER_LINEAR) return base_lo + beat;
      else                     return base_lo ^ beat;
   endfunction

endpackage

// File: rtl/fts_burst_ctrl.sv
module fts_burst_ctrl
   import fts_sram_pkg::*;
#(
   parameter int ADDR_W = 10
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sleep,
   input  logic              start,
   input  logic              step,
   input  logic [ADDR_W-1:0] addr_in,
   input  burst_order_e      order_in,
   output logic [ADDR_W-1:0] cur_addr,
   output logic              active,
   output burst_order_e      order
);
   localparam int HI_W = ADDR_W - 2;

   logic [HI_W-1:0] hi_q;
   logic [1:0]      lo_q;
   logic [1:0]      beat_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         hi_q   <= '0;
         lo_q   <= '0;
         beat_q <= '0;
         active <= 1'b0;
         order  <= ORDER_LINEAR;
      end else if (sleep) begin
         beat_q <= '0;
         active <= 1'b0;
      end else if (start) begin
         hi_q   <= addr_in[ADDR_W-1:2];
         lo_q   <= addr_in[1:0];
         beat_q <= '0;
         active <= 1'b1;
         order  <= order_in;
      end else if (step && active) begin
         beat_q <= beat_q + 2'd1;
      end
   end

   assign cur_addr = {hi_q, beat_offset(lo_q, beat_q, order)};

endmodule

// File: rtl/fts_sram_array.sv
module fts_sram_array #(
   parameter int ADDR_W = 10,
   parameter int DATA_W = 32,
   parameter int LANE_W = 8
) (
   input  logic                     clk,
   input  logic                     wr_en,
   input  logic [DATA_W/LANE_W-1:0] lane_en,
   input  logic [ADDR_W-1:0]        waddr,
   input  logic [DATA_W-1:0]        wdata,
   input  logic [ADDR_W-1:0]        raddr,
   output logic [DATA_W-1:0]        rdata
);
   localparam int DEPTH = 1 << ADDR_W;
   localparam int LANES = DATA_W / LANE_W;

   for (genvar g = 0; g < LANES; g++) begin : g_lane
      logic [LANE_W-1:0] cells [DEPTH];

      always_ff @(posedge clk) begin
         if (wr_en && lane_en[g]) cells[waddr] <= wdata[g*LANE_W +: LANE_W];
      end

      // Flow-through: no output register on the read side.
      assign rdata[g*LANE_W +: LANE_W] = cells[raddr];
   end

endmodule

// File: rtl/fts_burst_sram.sv
module fts_burst_sram
   import fts_sram_pkg::*;
#(
   parameter int ADDR_W = 10,
   parameter int DATA_W = 32,
   parameter int LANE_W = 8
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic [ADDR_W-1:0]        addr,
   input  logic                     cpu_strobe,
   input  logic                     ctl_strobe,
   input  logic                     adv,
   input  logic                     lin_mode,
   input  logic                     wr,
   input  logic [DATA_W/LANE_W-1:0] byte_we,
   input  logic                     oe,
   input  logic                     sleep,
   inout  wire  [DATA_W-1:0]        data
);
   localparam int LANES = DATA_W / LANE_W;

   if (ADDR_W < 2) begin : g_bad_addr
      $error("fts_burst_sram: ADDR_W must cover a group of four beats");
   end
   if (LANE_W < 1 || DATA_W % LANE_W != 0) begin : g_bad_lane
      $error("fts_burst_sram: DATA_W must be a whole number of lanes");
   end
   if (LANES > 16) begin : g_bad_lanes
      $error("fts_burst_sram: too many byte lanes");
   end

   logic              start_any;
   logic              wr_fire;
   logic              drive_en;
   logic              active;
   logic [ADDR_W-1:0] cur_addr;
   logic [DATA_W-1:0] rd_word;
   burst_order_e      burst_ord;

   assign start_any = cpu_strobe | ctl_strobe;

   fts_burst_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
      .clk      (clk),
      .rst_n    (rst_n),
      .sleep    (sleep),
      .start    (start_any),
      .step     (adv),
      .addr_in  (addr),
      .order_in (burst_order_e'(lin_mode)),
      .cur_addr (cur_addr),
      .active   (active),
      .order    (burst_ord)
   );

   assign wr_fire = wr && active && !sleep;

   fts_sram_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .LANE_W(LANE_W)) u_array (
      .clk     (clk),
      .wr_en   (wr_fire),
      .lane_en (byte_we),
      .waddr   (cur_addr),
      .wdata   (data),
      .raddr   (cur_addr),
      .rdata   (rd_word)
   );

   // Asynchronous output enable: no register between oe and the drivers.
   assign drive_en = active && oe && !wr && !sleep;
   assign data     = drive_en ? rd_word : 'z;

endmodule

// File: rtl/fts_sram_checker.sv
module fts_sram_checker
   import fts_sram_pkg::*;
#(
   parameter int ADDR_W = 10
) (
   input logic              clk,
   input logic              rst_n,
   input logic              sleep,
   input logic              oe,
   input logic              wr,
   input logic              adv,
   input logic              start_any,
   input logic [ADDR_W-1:0] addr,
   input logic [ADDR_W-1:0] cur_addr,
   input logic              active,
   input logic              drive_en,
   input burst_order_e      burst_ord
);
   a_r5_strobe_loads: assert property (@(posedge clk) disable iff (!rst_n)
      (start_any && !sleep) |=> (active && cur_addr == $past(addr)));

   a_r6_hold_without_adv: assert property (@(posedge clk) disable iff (!rst_n)
      (active && !sleep && !start_any && !adv) |=> $stable(cur_addr));

   a_r4_upper_fixed: assert property (@(posedge clk) disable iff (!rst_n)
      (active && !sleep && !start_any) |=>
         cur_addr[ADDR_W-1:2] == $past(cur_addr[ADDR_W-1:2]));

   a_r3_linear_step: assert property (@(posedge clk) disable iff (!rst_n)
      (active && !sleep && !start_any && adv && burst_ord == ORDER_LINEAR) |=>
         cur_addr[1:0] == $past(cur_addr[1:0]) + 2'd1);

   a_r8_release_bus: assert property (@(posedge clk) disable iff (!rst_n)
      (!oe || wr) |-> !drive_en);

   a_r9_sleep_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      sleep |-> !drive_en);

   a_r10_wake_idle: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(sleep) |-> !active);

endmodule

bind fts_burst_sram fts_sram_checker #(.ADDR_W(ADDR_W)) u_checker (
   .clk       (clk),
   .rst_n     (rst_n),
   .sleep     (sleep),
   .oe        (oe),
   .wr        (wr),
   .adv       (adv),
   .start_any (start_any),
   .addr      (addr),
   .cur_addr  (cur_addr),
   .active    (active),
   .drive_en  (drive_en),
   .burst_ord (burst_ord)
);

// File: tb/tb_fts_burst_sram.sv
module tb_fts_burst_sram;
   localparam int AW    = 10;
   localparam int DW    = 32;
   localparam int LN    = DW / 8;
   localparam int DEPTH = 1 << AW;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [AW-1:0] addr = '0;
   logic          cpu_strobe = 1'b0, ctl_strobe = 1'b0, adv = 1'b0;
   logic          lin_mode = 1'b1, wr = 1'b0, oe = 1'b0, sleep = 1'b0;
   logic [LN-1:0] byte_we = '0;
   logic          tb_drv = 1'b0;
   logic [DW-1:0] tb_val = '0;
   tri1  [DW-1:0] data;

   assign data = tb_drv ? tb_val : 'z;

   always #5 clk = ~clk;

   fts_burst_sram #(.ADDR_W(AW), .DATA_W(DW), .LANE_W(8)) dut (
      .clk(clk), .rst_n(rst_n), .addr(addr), .cpu_strobe(cpu_strobe),
      .ctl_strobe(ctl_strobe), .adv(adv), .lin_mode(lin_mode), .wr(wr),
      .byte_we(byte_we), .oe(oe), .sleep(sleep), .data(data));

   // Bench-side model of the storage and the burst pointer.
   logic [DW-1:0] model [DEPTH];
   logic [AW-1:0] b_base = '0;
   logic [1:0]    b_beat = '0;
   logic          b_lin = 1'b1;
   logic          b_act = 1'b0;
   int            errors = 0;
   int            checks = 0;
   bit            done = 1'b0;

   function automatic logic [AW-1:0] exp_addr();
      logic [1:0] lo;
      lo = b_lin ? (b_base[1:0] + b_beat) : (b_base[1:0] ^ b_beat);
      return {b_base[AW-1:2], lo};
   endfunction

   function automatic logic [DW-1:0] exp_bus();
      if (b_act && oe && !wr && !sleep) return model[exp_addr()];
      return '1;
   endfunction

   task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: data=%h expected %h", req, act, exp);
      end
   endtask

   task automatic tick();
      @(posedge clk);
      @(negedge clk);
   endtask

   // One clock edge with the given controls; model updated after the edge.
   task automatic step(input bit s_cpu, input bit s_ctl, input logic [AW-1:0] a,
                       input bit lin, input bit do_adv, input bit do_wr,
                       input logic [LN-1:0] m, input logic [DW-1:0] v, input bit slp);
      cpu_strobe = s_cpu; ctl_strobe = s_ctl; addr = a; lin_mode = lin;
      adv = do_adv; wr = do_wr; byte_we = m; tb_val = v; tb_drv = do_wr; sleep = slp;
      tick();
      if (slp) begin
         b_act  = 1'b0;
         b_beat = '0;
      end else begin
         if (do_wr && b_act) begin
            for (int i = 0; i < LN; i++)
               if (m[i]) model[exp_addr()][i*8 +: 8] = v[i*8 +: 8];
         end
         if (s_cpu || s_ctl) begin
            b_base = a; b_beat = '0; b_act = 1'b1; b_lin = lin;
         end else if (do_adv && b_act) begin
            b_beat = b_beat + 2'd1;
         end
      end
      cpu_strobe = 1'b0; ctl_strobe = 1'b0; adv = 1'b0; wr = 1'b0;
      tb_drv = 1'b0; byte_we = '0; sleep = 1'b0;
   endtask

   task automatic chk_read(input string req);
      oe = 1'b1;
      #1;
      chk(req, data, exp_bus());
   endtask

   task automatic read_burst(input string req);
      for (int k = 0; k < 4; k++) begin
         chk_read(req);
         step(0, 0, '0, b_lin, 1, 0, '0, '0, 0);
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: data=%h expected %h", data, data);
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd20240611));
      repeat (3) tick();
      rst_n = 1'b1;
      tick();
      chk_read("R1");

      // Fill the whole array with linear write bursts (R7).
      for (int base = 0; base < DEPTH; base += 4) begin
         step(1, 0, AW'(base), 1, 0, 0, '0, '0, 0);
         for (int k = 0; k < 4; k++)
            step(0, 0, '0, 1, 1, 1, 4'hF, 32'h5A00_0000 ^ (32'(base + k) * 32'h9E37), 0);
      end

      // R2 / R3: linear burst from an unaligned start: 2,3,0,1.
      step(1, 0, AW'(10'h0A6), 1, 0, 0, '0, '0, 0);
      read_burst("R3");
      // R4: interleaved burst from offset 1: 1,0,3,2.
      step(0, 1, AW'(10'h131), 0, 0, 0, '0, '0, 0);
      read_burst("R4");
      chk_read("R6");   // wrapped back to beat 0 after four steps
      // R6: hold without advance.
      step(0, 0, '0, 0, 0, 0, '0, '0, 0);
      chk_read("R6");
      step(0, 0, '0, 0, 0, 0, '0, '0, 0);
      chk_read("R6");
      // R5: strobe beats advance in the same cycle.
      step(0, 1, AW'(10'h2F3), 1, 1, 0, '0, '0, 0);
      chk_read("R5");
      step(1, 0, AW'(10'h044), 1, 0, 0, '0, '0, 0);
      chk_read("R2");
      // R7: partial lane write, then read back.
      step(0, 0, '0, 1, 0, 1, 4'b0101, 32'hAABB_CCDD, 0);
      chk_read("R7");
      // R8: oe drop and wr flag release the bus mid-cycle.
      #2 oe = 1'b0; #1 chk("R8", data, 32'hFFFF_FFFF);
      oe = 1'b1; wr = 1'b1; #1 chk("R8", data, 32'hFFFF_FFFF);
      wr = 1'b0; #1 chk("R8", data, model[exp_addr()]);
      @(negedge clk);
      // R11: write and strobe on the same edge.
      step(1, 0, AW'(10'h100), 1, 0, 1, 4'hF, 32'h0BAD_F00D, 0);
      chk_read("R11");
      step(0, 1, AW'(10'h044), 1, 0, 0, '0, '0, 0);
      chk_read("R11");
      // R9 / R10: sleep with every other control asserted.
      step(1, 1, AW'(10'h200), 0, 1, 1, 4'hF, 32'h1111_2222, 1);
      sleep = 1'b1; oe = 1'b1; #1 chk("R9", data, 32'hFFFF_FFFF);
      sleep = 1'b0;
      chk_read("R10");
      step(0, 0, '0, 1, 1, 1, 4'hF, 32'h3333_4444, 0);
      chk_read("R10");
      step(1, 0, AW'(10'h044), 1, 0, 0, '0, '0, 0);
      chk_read("R9");
      step(1, 0, AW'(10'h200), 1, 0, 0, '0, '0, 0);
      chk_read("R9");

      // Random mix of strobes, writes, advances, holds and sleep.
      for (int n = 0; n < 3000; n++) begin
         int unsigned r;
         r = $urandom;
         if (r[3:0] == 4'd0)
            step(r[4], ~r[4], AW'($urandom), r[5], r[6], r[7], 4'($urandom), $urandom, r[9:8] == 2'd0);
         else if (r[3:0] < 4'd4)
            step(r[4], r[5] & ~r[4], AW'($urandom), r[6], r[7], r[8], 4'($urandom), $urandom, 0);
         else
            step(0, 0, '0, 0, r[4] | r[5], r[6] & r[7], 4'($urandom), $urandom, 0);
         oe = r[10] | r[11];
         #1 chk(r[8] ? "R7" : "R6", data, exp_bus());
      end

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule